// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit computes the quotient or the remainder of two integer operands for a 64-bit register machine. It handles unsigned and signed operands, at either the full 64-bit width or a narrow 32-bit width. A single-cycle start pulse captures the dividend, which is the old destination value, and the divisor, which has already been formed by operand fetch. Along with them it captures three selects: width, signedness, and quotient versus remainder. The unit then works for a fixed number of cycles that depends only on the width, and returns the new 64-bit destination value with a one-cycle done pulse.

The arithmetic is a restoring shift-subtract loop on operand magnitudes that produces one quotient bit per cycle. Signs are restored at the end. Signed results truncate toward zero. A zero divisor never traps: a quotient request yields zero, and a remainder request yields the dividend. An overflowing signed divide (most negative value by minus one) wraps instead of faulting.

Top module: `divmod_unit`

## Requirements
- R1: Unsigned quotient: with signSel=0 and remSel=0 the result is floor(dividend/divisor), using all 64 bits when wideSel=1.
- R2: Unsigned remainder: with signSel=0 and remSel=1 the result is dividend minus divisor times the unsigned quotient.
- R3: Signed quotient (signSel=1, remSel=0) treats operands as two's complement and truncates toward zero; for example -13/3 gives -4 and 13/-3 gives -4.
- R4: Signed remainder (signSel=1, remSel=1) follows truncating division, so it carries the dividend's sign; -13 rem 3 gives -1 and 13 rem -3 gives 1.
- R5: When the divisor (its low 32 bits for wideSel=0) is zero, a quotient request returns 0.
- R6: When the divisor is zero, a remainder request returns the full dividend for wideSel=1, and the low 32 dividend bits with the upper 32 bits zero for wideSel=0.
- R7: With wideSel=0 only the low 32 bits of each operand are used, and the 32-bit result is zero-extended into the 64-bit output.
- R8: A signed divide of the most negative value by -1 returns the most negative value of that width, and the matching remainder is 0.
- R9: Let the rising edge that samples startIn in the idle state be edge 0. Then busyOut is high from edge 0 until edge W+1, and doneOut is high for exactly the one cycle following edge W+1, where W is 64 when wideSel=1 and 32 when wideSel=0. After reset both flags and the result are zero.
- R10: A start pulse that arrives while busyOut is high is ignored: the running operation keeps its operands, its result and its latency.
- R11: resultOut holds its value from the done cycle until a later operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start pulse, accepted only while idle |
| dividendIn | input | 64 | Dividend (old destination value) |
| divisorIn | input | 64 | Divisor |
| wideSel | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| signSel | input | 1 | 1 selects signed, 0 unsigned |
| remSel | input | 1 | 1 returns the remainder, 0 the quotient |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | One-cycle pulse when the result is valid |
| resultOut | output | 64 | New destination value |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath and a 32-bit narrow mode. Both iteration lengths, 33 and 65 cycles to done, are therefore exercised, and the bench measures each of them on every operation. Because the narrow width is exactly half the full width, narrow operations run with arbitrary upper operand bits. This makes the masking on the way in and the zero extension on the way out observable. At these widths, the most-negative-by-minus-one wrap and the zero-divisor rules can be reached directly at both sizes, alongside a seeded random mix that includes small divisors so that quotients are multi-bit.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } dmStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dmState_t;
endpackage

// File: rtl/divmod_ctrl.sv
module divmod_ctrl
  import divmod_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      wideIn,
  output dmStrobe_t strobeOut,
  output logic      busyOut
);
  localparam int CNT_W = $clog2(DATA_W);

  dmState_t   state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startIn) begin
          state   <= ST_RUN;
          stepCnt <= wideIn ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);
        end
        ST_RUN: begin
          if (stepCnt == '0) state <= ST_FIN;
          else               stepCnt <= stepCnt - 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobeOut.load   = (state == ST_IDLE) && startIn;
    strobeOut.step   = (state == ST_RUN);
    strobeOut.finish = (state == ST_FIN);
  end

  assign busyOut = (state != ST_IDLE);

  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !strobeOut.finish) |=> busyOut);

  // R9
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeOut.finish |=> !busyOut);
endmodule

// File: rtl/divmod_dp.sv
module divmod_dp
  import divmod_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmStrobe_t         strobeIn,
  input  logic [DATA_W-1:0] dividendIn,
  input  logic [DATA_W-1:0] divisorIn,
  input  logic              wideIn,
  input  logic              signIn,
  input  logic              remIn,
  output logic              doneOut,
  output logic [DATA_W-1:0] resultOut
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] remReg, quoReg, divMag;
  logic negQ, negR, zeroDiv, wideReg, remReg_sel;

  // operand magnitudes at load
  logic [NARROW_W-1:0] aLo, bLo;
  logic aNeg, bNeg;
  logic [DATA_W-1:0] aMag, bMag;

  always_comb begin
    aLo = dividendIn[NARROW_W-1:0];
    bLo = divisorIn[NARROW_W-1:0];
    if (wideIn) begin
      aNeg = signIn & dividendIn[DATA_W-1];
      bNeg = signIn & divisorIn[DATA_W-1];
      aMag = aNeg ? -dividendIn : dividendIn;
      bMag = bNeg ? -divisorIn  : divisorIn;
    end else begin
      aNeg = signIn & aLo[NARROW_W-1];
      bNeg = signIn & bLo[NARROW_W-1];
      aMag = {{PAD_W{1'b0}}, (aNeg ? -aLo : aLo)};
      bMag = {{PAD_W{1'b0}}, (bNeg ? -bLo : bLo)};
    end
  end

  // one restoring step
  logic [DATA_W:0] shifted, trial;
  logic            fits;
  always_comb begin
    shifted = {remReg, quoReg[DATA_W-1]};
    trial   = shifted - {1'b0, divMag};
    fits    = !trial[DATA_W];
  end

  // final sign fix-up and width shaping
  logic [DATA_W-1:0] qFix, rFix, pick;
  always_comb begin
    qFix = negQ ? -quoReg : quoReg;
    rFix = negR ? -remReg : remReg;
    if (remReg_sel)   pick = rFix;
    else if (zeroDiv) pick = '0;
    else              pick = qFix;
    if (!wideReg) pick = {{PAD_W{1'b0}}, pick[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg     <= '0;
      quoReg     <= '0;
      divMag     <= '0;
      negQ       <= 1'b0;
      negR       <= 1'b0;
      zeroDiv    <= 1'b0;
      wideReg    <= 1'b0;
      remReg_sel <= 1'b0;
      resultOut  <= '0;
      doneOut    <= 1'b0;
    end else begin
      doneOut <= strobeIn.finish;
      if (strobeIn.load) begin
        remReg     <= '0;
        quoReg     <= wideIn ? aMag : (aMag << PAD_W);
        divMag     <= bMag;
        negQ       <= aNeg ^ bNeg;
        negR       <= aNeg;
        zeroDiv    <= (bMag == '0);
        wideReg    <= wideIn;
        remReg_sel <= remIn;
      end else if (strobeIn.step) begin
        remReg <= fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
        quoReg <= {quoReg[DATA_W-2:0], fits};
      end
      if (strobeIn.finish) resultOut <= pick;
    end
  end

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R7
  narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !wideReg) |-> (resultOut[DATA_W-1:NARROW_W] == '0));
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [DATA_W-1:0] dividendIn,
  input  logic [DATA_W-1:0] divisorIn,
  input  logic              wideSel,
  input  logic              signSel,
  input  logic              remSel,
  output logic              busyOut,
  output logic              doneOut,
  output logic [DATA_W-1:0] resultOut
);
  dmStrobe_t strobe;

  divmod_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .wideIn(wideSel),
    .strobeOut(strobe), .busyOut(busyOut)
  );

  divmod_dp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobeIn(strobe),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .wideIn(wideSel), .signIn(signSel), .remIn(remSel),
    .doneOut(doneOut), .resultOut(resultOut)
  );

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> doneOut);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |=> $stable(resultOut));
endmodule

// File: tb/divmod_unit_tb.sv
`timescale 1ns/1ps
module divmod_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dividend = '0, divisor = '0;
  logic        wide = 1'b0, sgn = 1'b0, rem = 1'b0;
  logic        busy, done;
  logic [63:0] result;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  divmod_unit u_dut (
    .clk(clk), .rstN(rstN), .startIn(start),
    .dividendIn(dividend), .divisorIn(divisor),
    .wideSel(wide), .signSel(sgn), .remSel(rem),
    .busyOut(busy), .doneOut(done), .resultOut(result)
  );

  function automatic logic [63:0] refModel(logic [63:0] a, logic [63:0] b,
                                           logic w, logic s, logic r);
    longint sa, sb;
    int     ia, ib;
    logic [31:0] a32, b32, q32;
    if (w) begin
      if (b == 64'd0) return r ? a : 64'd0;
      if (s) begin
        sa = a; sb = b;
        if (a == 64'h8000_0000_0000_0000 && b == '1) return r ? 64'd0 : a;
        return r ? 64'(sa % sb) : 64'(sa / sb);
      end
      return r ? a % b : a / b;
    end
    a32 = a[31:0]; b32 = b[31:0];
    if (b32 == 32'd0) return r ? {32'd0, a32} : 64'd0;
    if (s) begin
      ia = a32; ib = b32;
      if (a32 == 32'h8000_0000 && b32 == '1) q32 = r ? 32'd0 : a32;
      else q32 = r ? 32'(ia % ib) : 32'(ia / ib);
    end else q32 = r ? a32 % b32 : a32 / b32;
    return {32'd0, q32};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic w,
                       input logic s, input logic r, input string tag, input int injectAt);
    logic [63:0] exp;
    int cnt;
    exp = refModel(a, b, w, s, r);
    @(negedge clk);
    dividend = a; divisor = b; wide = w; sgn = s; rem = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt = 0;
    while (!done && cnt < 200) begin
      start = (cnt == injectAt);
      if (cnt == injectAt) begin
        dividend = ~a; divisor = b + 64'd3; wide = ~w; rem = ~r;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check({tag, " result"}, result, exp);
    // R9 latency W+1 edges after the sampling edge
    check("R9 latency", 64'(cnt), w ? 64'd65 : 64'd33);
    @(negedge clk);
    check("R9 single done", {63'd0, done}, 64'd0);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [63:0] hold;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset busy", {63'd0, busy}, 64'd0);
    check("R9 reset done", {63'd0, done}, 64'd0);
    check("R9 reset result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    runOp(64'd100, 64'd7, 1, 0, 0, "R1", -1);
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1, 0, 0, "R1", -1);
    runOp(64'h0000_0000_FFFF_FFFF, 64'd2, 0, 0, 0, "R1", -1);
    // R2
    runOp(64'd100, 64'd7, 1, 0, 1, "R2", -1);
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0001, 1, 0, 1, "R2", -1);
    // R3
    runOp(-64'sd13, 64'd3, 1, 1, 0, "R3", -1);
    runOp(64'd13, -64'sd3, 1, 1, 0, "R3", -1);
    runOp({32'h0, 32'hFFFF_FFF3}, 64'd3, 0, 1, 0, "R3", -1);
    // R4
    runOp(-64'sd13, 64'd3, 1, 1, 1, "R4", -1);
    runOp(64'd13, -64'sd3, 1, 1, 1, "R4", -1);
    runOp({32'h0, 32'hFFFF_FFF3}, 64'd3, 0, 1, 1, "R4", -1);
    // R5
    runOp(64'h1234_5678_9ABC_DEF0, 64'd0, 1, 0, 0, "R5", -1);
    runOp(64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_0000_0000, 0, 1, 0, "R5", -1);
    // R6
    runOp(64'h8765_4321_0FED_CBA9, 64'd0, 1, 1, 1, "R6", -1);
    runOp(64'h8765_4321_8FED_CBA9, 64'hABCD_0000_0000_0000, 0, 1, 1, "R6", -1);
    runOp(64'h8765_4321_8FED_CBA9, 64'd0, 0, 0, 1, "R6", -1);
    // R7 upper garbage ignored
    runOp(64'hDEAD_BEEF_0000_0064, 64'hCAFE_F00D_0000_0007, 0, 0, 0, "R7", -1);
    runOp(64'hDEAD_BEEF_FFFF_FF9C, 64'hCAFE_F00D_0000_0007, 0, 1, 1, "R7", -1);
    // R8
    runOp(64'h8000_0000_0000_0000, '1, 1, 1, 0, "R8", -1);
    runOp(64'h8000_0000_0000_0000, '1, 1, 1, 1, "R8", -1);
    runOp(64'h1111_1111_8000_0000, 64'h2222_2222_FFFF_FFFF, 0, 1, 0, "R8", -1);
    runOp(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0, 1, 1, "R8", -1);
    // R10 start during run is ignored
    runOp(64'd1000, 64'd9, 1, 0, 0, "R10", 5);
    runOp(64'd1000, 64'd9, 0, 1, 1, "R10", 20);
    // R11 stability with start low
    hold = result;
    repeat (4) @(negedge clk);
    check("R11 hold", result, hold);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      logic w, s, r;
      string tag;
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = 64'($urandom % 16);
        1: b = {32'd0, $urandom};
        default: b = {$urandom, $urandom};
      endcase
      if ($urandom % 3 == 0) a = {{32{a[31]}}, a[31:0]};
      w = 1'($urandom); s = 1'($urandom); r = 1'($urandom);
      tag = r ? (s ? "R4" : "R2") : (s ? "R3" : "R1");
      runOp(a, b, w, s, r, tag, -1);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule